// File: doc/BRIEF.md
# Bit-Band Alias Bridge

This bridge sits between one bus master and a word-addressed memory or peripheral slave. Part of the address map is set aside as a 32 MB alias window. Each word in that window stands for one bit of a 1 MB backing region.

A write to an alias word becomes a locked read-modify-write on the backing word. The write sets or clears exactly one bit and leaves every other bit as it was. A read of an alias word returns the addressed bit, zero-extended to the full data width. Any address outside the window is forwarded to the slave unchanged.

While the read-modify-write runs, a lock output is held high. A system arbiter uses this lock to keep other masters away from the slave until the write-back completes.

The master holds a request until it sees a one-cycle ready pulse. The slave answers each cycle of its request with a one-cycle ready, and read data is valid during that pulse.

Top module: `bb_alias_bridge`

## Requirements
- R1: An access is an alias access exactly when its address lies in [ALIAS_BASE, ALIAS_BASE + 2^ALIAS_LOG2). The defaults are 0x42000000 and a 32 MB window, so 0x41FFFFFC and 0x44000000 are forwarded and 0x42000000 and 0x43FFFFFC are alias accesses.
- R2: For an alias address A, let off = A - ALIAS_BASE. Then byte = off[24:5] and bit = off[4:2]. The backing word address is BACK_BASE + (byte with its two low bits cleared). The bit position inside the 32-bit word is byte[1:0]*8 + bit. For example, alias 0x422181A0 selects bit 8 of word 0x40010C0C.
- R3: An alias write writes back the backing word with the selected bit replaced by wdata bit 0. All other 31 bits are unchanged, and wdata bits 31..1 have no effect.
- R4: An alias write performs one slave read and then one slave write, both to the same backing word address, in that order.
- R5: sLock is high during both slave accesses of an alias write. It is low during every forwarded access and every alias read.
- R6: An alias read issues one slave read of the backing word and no slave write. It returns the selected bit in rdata bit 0, with bits 31..1 equal to zero.
- R7: A forwarded access passes address, direction and write data to the slave unchanged. A forwarded read returns the slave data unchanged.
- R8: After reset, mReady, sReq and sLock are low. Each accepted request is answered by mReady high for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| mReq | input | 1 | Master request, held until mReady |
| mWrite | input | 1 | Master write (1) or read (0) |
| mAddr | input | AW | Master byte address |
| mWdata | input | DW | Master write data |
| mReady | output | 1 | One-cycle completion pulse |
| mRdata | output | DW | Read data to master, valid with mReady |
| sReq | output | 1 | Slave request |
| sWrite | output | 1 | Slave write (1) or read (0) |
| sLock | output | 1 | Slave held exclusively for a read-modify-write |
| sAddr | output | AW | Slave byte address |
| sWdata | output | DW | Slave write data |
| sReady | input | 1 | Slave completion pulse |
| sRdata | input | DW | Slave read data, valid with sReady |

## Verification
The bench targets several corner cases, and each one exposes a specific kind of faulty design:

- **Every bit of one backing word, set and cleared with junk in the upper write-data bits.** A lane or bit-number swap touches the wrong bit. A design that writes raw write data corrupts the word.
- **The window edges 0x42000000 and 0x43FFFFFC, plus the neighbouring addresses just outside.** An off-by-one range decode either forwards an alias address or bit-bands a normal one.
- **Alias reads.** These catch a bridge that leaks neighbouring bits into the upper result, or one that writes back on a read.
- **Slave-side traces.** The recorded order, address and lock state catch a write-back to a different word, a missing lock, or a lock left asserted on plain traffic.

// File: rtl/bb_pkg.sv
package bb_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PASS,
    ST_BREAD,
    ST_RMW_RD,
    ST_RMW_WR,
    ST_RESP
  } bbState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic useBacking;  // drive translated backing address
    logic wrSlave;     // slave access is a write
    logic capWord;     // capture backing word for modify
    logic capResp;     // capture response for master
    logic respBit;     // response is a single extracted bit
  } bbStrobes_t;

endpackage

// File: rtl/bb_datapath.sv
module bb_datapath
  import bb_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int ALIAS_LOG2 = 25,
  parameter logic [AW-1:0] ALIAS_BASE = 32'h4200_0000,
  parameter logic [AW-1:0] BACK_BASE  = 32'h4000_0000
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [AW-1:0] mAddr,
  input  logic [DW-1:0] mWdata,
  input  logic [DW-1:0] sRdata,
  input  bbStrobes_t    strb,
  output logic          hitAlias,
  output logic [AW-1:0] sAddr,
  output logic [DW-1:0] sWdata,
  output logic [DW-1:0] mRdata
);

  localparam int LANE_W = $clog2(DW / 8);
  localparam int BSEL_W = 3;
  localparam int BIT_W  = LANE_W + BSEL_W;
  localparam int LOW_W  = BIT_W;  // alias address bits below the byte offset
  localparam int BYTE_W = ALIAS_LOG2 - LOW_W;

  logic [ALIAS_LOG2-1:0] aliasOff;
  logic [BYTE_W-1:0]     byteOff;
  logic [BSEL_W-1:0]     bitSel;
  logic [BIT_W-1:0]      bitPos;
  logic [AW-1:0]         backAddr;
  logic [DW-1:0]         heldWord;
  logic [DW-1:0]         modWord;
  logic [DW-1:0]         respData;

  // Window decode: base is aligned to the window size
  assign hitAlias = (mAddr[AW-1:ALIAS_LOG2] == ALIAS_BASE[AW-1:ALIAS_LOG2]);
  assign aliasOff = mAddr[ALIAS_LOG2-1:0];
  assign byteOff  = aliasOff[ALIAS_LOG2-1:LOW_W];
  assign bitSel   = aliasOff[LOW_W-1:2];
  assign bitPos   = {byteOff[LANE_W-1:0], bitSel};
  assign backAddr = BACK_BASE + AW'({byteOff[BYTE_W-1:LANE_W], {LANE_W{1'b0}}});

  assign sAddr = strb.useBacking ? backAddr : mAddr;

  // Single-bit merge into captured backing word
  always_comb begin
    modWord         = heldWord;
    modWord[bitPos] = mWdata[0];
  end

  assign sWdata = strb.useBacking ? modWord : mWdata;

  // Response: either whole word or a zero-extended selected bit
  always_comb begin
    respData = sRdata;
    if (strb.respBit) begin
      respData    = '0;
      respData[0] = sRdata[bitPos];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      heldWord <= '0;
      mRdata   <= '0;
    end else begin
      if (strb.capWord) heldWord <= sRdata;
      if (strb.capResp) mRdata   <= respData;
    end
  end

  AST_RMW_ONE_BIT: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrSlave && strb.useBacking) |-> ($countones(sWdata ^ heldWord) <= 1)); // R3

  AST_RMW_BIT_VALUE: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrSlave && strb.useBacking) |-> (sWdata[bitPos] == mWdata[0])); // R3

endmodule

// File: rtl/bb_control.sv
module bb_control
  import bb_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       mReq,
  input  logic       mWrite,
  input  logic       hitAlias,
  input  logic       sReady,
  output bbStrobes_t strb,
  output logic       sReq,
  output logic       sWrite,
  output logic       sLock,
  output logic       mReady
);

  bbState_t state, stateNx;

  always_comb begin
    stateNx = state;
    unique case (state)
      ST_IDLE: begin
        if (mReq) begin
          if (!hitAlias)   stateNx = ST_PASS;
          else if (mWrite) stateNx = ST_RMW_RD;
          else             stateNx = ST_BREAD;
        end
      end
      ST_PASS, ST_BREAD: if (sReady) stateNx = ST_RESP;
      ST_RMW_RD:         if (sReady) stateNx = ST_RMW_WR;
      ST_RMW_WR:         if (sReady) stateNx = ST_RESP;
      ST_RESP:           stateNx = ST_IDLE;
      default:           stateNx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNx;
  end

  assign sReq   = (state == ST_PASS) || (state == ST_BREAD) ||
                  (state == ST_RMW_RD) || (state == ST_RMW_WR);
  assign sWrite = ((state == ST_PASS) && mWrite) || (state == ST_RMW_WR);
  assign sLock  = (state == ST_RMW_RD) || (state == ST_RMW_WR);
  assign mReady = (state == ST_RESP);

  always_comb begin
    strb.useBacking = (state == ST_BREAD) || (state == ST_RMW_RD) || (state == ST_RMW_WR);
    strb.wrSlave    = sWrite;
    strb.capWord    = (state == ST_RMW_RD) && sReady;
    strb.capResp    = ((state == ST_PASS) || (state == ST_BREAD)) && sReady;
    strb.respBit    = (state == ST_BREAD);
  end

  AST_READY_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    mReady |=> !mReady); // R8

  AST_LOCK_ONLY_ALIAS_WR: assert property (@(posedge clk) disable iff (!rstN)
    sLock |-> (mReq && mWrite && hitAlias)); // R5

endmodule

// File: rtl/bb_alias_bridge.sv
module bb_alias_bridge
  import bb_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int ALIAS_LOG2 = 25,
  parameter logic [AW-1:0] ALIAS_BASE = 32'h4200_0000,
  parameter logic [AW-1:0] BACK_BASE  = 32'h4000_0000
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          mReq,
  input  logic          mWrite,
  input  logic [AW-1:0] mAddr,
  input  logic [DW-1:0] mWdata,
  output logic          mReady,
  output logic [DW-1:0] mRdata,
  output logic          sReq,
  output logic          sWrite,
  output logic          sLock,
  output logic [AW-1:0] sAddr,
  output logic [DW-1:0] sWdata,
  input  logic          sReady,
  input  logic [DW-1:0] sRdata
);

  bbStrobes_t strb;
  logic       hitAlias;

  bb_control u_ctrl (
    .clk(clk), .rstN(rstN), .mReq(mReq), .mWrite(mWrite),
    .hitAlias(hitAlias), .sReady(sReady), .strb(strb),
    .sReq(sReq), .sWrite(sWrite), .sLock(sLock), .mReady(mReady)
  );

  bb_datapath #(
    .AW(AW), .DW(DW), .ALIAS_LOG2(ALIAS_LOG2),
    .ALIAS_BASE(ALIAS_BASE), .BACK_BASE(BACK_BASE)
  ) u_dp (
    .clk(clk), .rstN(rstN), .mAddr(mAddr), .mWdata(mWdata),
    .sRdata(sRdata), .strb(strb), .hitAlias(hitAlias),
    .sAddr(sAddr), .sWdata(sWdata), .mRdata(mRdata)
  );

  AST_RMW_SAME_WORD: assert property (@(posedge clk) disable iff (!rstN)
    (sReq && sWrite && sLock && $past(sReq && !sWrite && sLock)) |->
      (sAddr == $past(sAddr))); // R4

  AST_LOCK_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rstN)
    sLock |-> sReq); // R5

endmodule

// File: tb/tb_bb_alias_bridge.sv
module tb_bb_alias_bridge;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        mReq = 1'b0, mWrite = 1'b0;
  logic [31:0] mAddr = '0, mWdata = '0;
  logic        mReady;
  logic [31:0] mRdata;
  logic        sReq, sWrite, sLock;
  logic [31:0] sAddr, sWdata;
  logic        sReady;
  logic [31:0] sRdata;

  always #4 clk = ~clk;  // 125 MHz

  bb_alias_bridge dut (
    .clk(clk), .rstN(rstN), .mReq(mReq), .mWrite(mWrite), .mAddr(mAddr),
    .mWdata(mWdata), .mReady(mReady), .mRdata(mRdata), .sReq(sReq),
    .sWrite(sWrite), .sLock(sLock), .sAddr(sAddr), .sWdata(sWdata),
    .sReady(sReady), .sRdata(sRdata)
  );

  // Slave model: 16 words indexed by address bits [5:2], plus a trace
  logic [31:0] mem [16];
  int          wrCount, rdCount;
  logic [31:0] lastWrAddr, lastRdAddr;
  logic        wrLock, rdLock, lastWasRead, wrAfterRdSame;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sReady <= 1'b0; sRdata <= '0; wrCount <= 0; rdCount <= 0;
      lastWrAddr <= '0; lastRdAddr <= '0; wrLock <= 1'b0; rdLock <= 1'b0;
      lastWasRead <= 1'b0; wrAfterRdSame <= 1'b0;
      for (int i = 0; i < 16; i++) mem[i] <= '0;
    end else if (sReq && !sReady) begin
      sReady <= 1'b1;
      if (sWrite) begin
        mem[sAddr[5:2]] <= sWdata;
        wrCount <= wrCount + 1;
        lastWrAddr <= sAddr;
        wrLock <= sLock;
        wrAfterRdSame <= lastWasRead && (lastRdAddr == sAddr);
      end else begin
        sRdata <= mem[sAddr[5:2]];
        rdCount <= rdCount + 1;
        lastRdAddr <= sAddr;
        rdLock <= sLock;
      end
      lastWasRead <= !sWrite;
    end else begin
      sReady <= 1'b0;
    end
  end

  int          nChecks = 0, nFails = 0;
  logic [31:0] model [16];
  bit          finished = 0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic access(input logic wr, input logic [31:0] a, input logic [31:0] d,
                        output logic [31:0] rd);
    int n = 0;
    @(negedge clk);
    mReq = 1'b1; mWrite = wr; mAddr = a; mWdata = d;
    forever begin
      @(negedge clk);
      n++;
      if (mReady) break;
      if (n > 100) begin
        nChecks++; nFails++;
        $display("FAIL R8: actual no mReady expected mReady for addr %h", a);
        break;
      end
    end
    rd = mRdata;
    mReq = 1'b0;
  endtask

  function automatic logic [31:0] aliasOf(input logic [31:0] wa, input int b);
    return 32'h4200_0000 + (((wa - 32'h4000_0000) + 32'(b / 8)) << 5) + 32'((b % 8) * 4);
  endfunction

  // Alias write with full trace checks
  task automatic aliasWrite(input logic [31:0] wa, input int b, input logic [31:0] d);
    logic [31:0] rd;
    int w0, r0;
    w0 = wrCount; r0 = rdCount;
    access(1'b1, aliasOf(wa, b), d, rd);
    model[wa[5:2]][b] = d[0];
    check("R4 one read", 32'(rdCount - r0), 32'd1);
    check("R4 one write", 32'(wrCount - w0), 32'd1);
    check("R2 backing addr", lastWrAddr, wa);
    check("R4 read-then-write same word", {31'd0, wrAfterRdSame}, 32'd1);
    check("R5 lock on read", {31'd0, rdLock}, 32'd1);
    check("R5 lock on write", {31'd0, wrLock}, 32'd1);
    check("R3 backing word", mem[wa[5:2]], model[wa[5:2]]);
  endtask

  task automatic aliasRead(input logic [31:0] wa, input int b);
    logic [31:0] rd;
    int w0;
    w0 = wrCount;
    access(1'b0, aliasOf(wa, b), 32'hFFFF_FFFF, rd);
    check("R6 bit read", rd, {31'd0, model[wa[5:2]][b]});
    check("R6 no slave write", 32'(wrCount - w0), 32'd0);
    check("R5 no lock on alias read", {31'd0, rdLock}, 32'd0);
    check("R2 alias read addr", lastRdAddr, wa);
  endtask

  task automatic passWrite(input logic [31:0] a, input logic [31:0] d);
    logic [31:0] rd;
    access(1'b1, a, d, rd);
    model[a[5:2]] = d;
    check("R7 pass addr", lastWrAddr, a);
    check("R7 pass data", mem[a[5:2]], d);
    check("R5 no lock on pass", {31'd0, wrLock}, 32'd0);
  endtask

  initial begin
    logic [31:0] rd;
    for (int i = 0; i < 16; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    check("R8 reset mReady", {31'd0, mReady}, 32'd0);
    check("R8 reset sReq", {31'd0, sReq}, 32'd0);
    check("R8 reset sLock", {31'd0, sLock}, 32'd0);
    rstN = 1'b1;

    // Preload through forwarded writes
    for (int i = 0; i < 16; i++)
      passWrite(32'h4001_0C00 + 32'(i * 4), 32'hA5C3_0000 ^ (32'(i) * 32'h0101_0107));
    access(1'b0, 32'h4001_0C0C, '0, rd);
    check("R7 pass read", rd, model[3]);
    @(negedge clk);
    check("R8 ready single pulse", {31'd0, mReady}, 32'd0);

    // Sweep all bits of one word: set, read, clear, read
    for (int b = 0; b < 32; b++) begin
      aliasWrite(32'h4001_0C0C, b, 32'h5A5A_5A5B ^ 32'(b << 4));
      aliasRead(32'h4001_0C0C, b);
      aliasWrite(32'h4001_0C0C, b, 32'hFFFF_FFFE);
      aliasRead(32'h4001_0C0C, b);
    end

    // Worked example: alias 0x422181A0 -> bit 8 of 0x40010C0C
    access(1'b1, 32'h4221_81A0, 32'h1, rd);
    model[3][8] = 1'b1;
    check("R2 example addr", lastWrAddr, 32'h4001_0C0C);
    check("R2 example word", mem[3], model[3]);

    // Window edges
    aliasWrite(32'h4000_0000, 0, 32'h1);
    aliasWrite(32'h400F_FFFC, 31, 32'h1);
    check("R1 top alias addr", aliasOf(32'h400F_FFFC, 31), 32'h43FF_FFFC);
    aliasRead(32'h400F_FFFC, 31);
    passWrite(32'h41FF_FFFC, 32'hDEAD_BEEF);
    check("R1 below window forwarded", lastWrAddr, 32'h41FF_FFFC);
    passWrite(32'h4400_0000, 32'h1234_5678);
    check("R1 above window forwarded", lastWrAddr, 32'h4400_0000);
    access(1'b0, 32'h4400_0000, '0, rd);
    check("R7 pass read above window", rd, 32'h1234_5678);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

endmodule